// File: doc/BRIEF.md
# Flash Block Lock Command Decoder

This block watches the write cycles that a host issues on a 16-bit flash command bus and decodes the two-write sequences that control erase-block protection. Each erase block has a locked bit and a lock-down bit. The locked bit drives that block's write-protect output. A block-protection sequence starts with the 0060h prefix. The value written in the second cycle then selects lock, unlock or lock-down for the block that the address names.

A second prefix, 00C0h, opens a protection-register sequence. At a word inside the protection-register window, the block hands the address and data to the one-time-programmable storage through a request/done handshake. That storage sits outside this block. At the lock-protection address, the value FFFDh freezes the protection area, and every later protection program is refused. Bad sequences set a sticky error flag, which the next valid prefix clears.

Top module: `blk_lock_dec`

## Requirements
- R1: During and right after reset, every bit of `wp_o` is 1, `err_o` is 0 and `prog_req_o` is 0.
- R2: The block index is `addr_i[ADDR_W-1:BLK_LSB]`. The writes 0060h then 0001h, both at the same address of block k, set `wp_o[k]` to 1. The new value shows after the clock edge that samples the second write.
- R3: The writes 0060h then 00D0h, at the same address of block k, clear `wp_o[k]` to 0, provided block k is not in lock-down. No other command clears a `wp_o` bit.
- R4: The writes 0060h then 002Fh put block k in lock-down and set `wp_o[k]`. After that, an unlock aimed at block k leaves `wp_o[k]` at 1 and sets `err_o`.
- R5: If the second write's address differs from the first write's address, `err_o` is set. No lock bit changes and no program request is raised. This holds for both prefixes.
- R6: After 0060h, any second value other than 0001h, 00D0h or 002Fh sets `err_o` and changes no `wp_o` bit. So does a block index of `NUM_BLK` or more.
- R7: The writes 00C0h then data D, both at a protection address in `[PR_BASE, PR_BASE+PR_WORDS)`, raise `prog_req_o` with `prog_addr_o` and `prog_data_o` equal to that address and D. The request stays high with stable outputs until `prog_done_i` is sampled high. All host writes are ignored while it is high.
- R8: The writes 00C0h then FFFDh at address `LPA` (default 0080h) freeze the protection area without an error. After that, every 00C0h sequence sets `err_o` and raises no request.
- R9: A 00C0h sequence sets `err_o` in either of two cases: its address is neither `LPA` nor inside the protection window, or its address is `LPA` and the data is not FFFDh.
- R10: `err_o` stays set until the next accepted 0060h or 00C0h first write clears it. In the idle state, writes of any other value are ignored.
- R11: Lock-down is cleared only by reset. After reset the block is locked and can be unlocked again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Host write strobe, one cycle per bus write |
| addr_i | input | ADDR_W | Host word address |
| data_i | input | 16 | Host write data |
| prog_done_i | input | 1 | Protection program finished |
| wp_o | output | NUM_BLK | Per-block write protect (1 = locked) |
| err_o | output | 1 | Sticky command error flag |
| prog_req_o | output | 1 | Protection program request |
| prog_addr_o | output | ADDR_W | Protection program address |
| prog_data_o | output | 16 | Protection program data |

## Verification
All results (the `wp_o` bits, `err_o` and the rise of `prog_req_o`) are registered on the clock edge that samples the second write of a sequence. They can therefore be read one cycle after that write is presented. The bench drives every write at a falling edge, removes it at the next falling edge, and reads outputs at that same falling edge, which lies half a period after the sampling edge. `err_o` is cleared on the edge that samples an accepted prefix, so it is checked right after the first write. `prog_req_o` falls on the edge that samples `prog_done_i`, so the bench checks it at the falling edge that follows the done pulse. Writes presented during a request are followed by reads of `wp_o`, which show that those writes were dropped.

// File: rtl/blk_lock_pkg.sv
`timescale 1ns/1ps
package blk_lock_pkg;
  localparam logic [15:0] OP_BLK     = 16'h0060;
  localparam logic [15:0] OP_PROT    = 16'h00C0;
  localparam logic [15:0] SUB_LOCK   = 16'h0001;
  localparam logic [15:0] SUB_UNLOCK = 16'h00D0;
  localparam logic [15:0] SUB_LDOWN  = 16'h002F;
  localparam logic [15:0] SUB_FREEZE = 16'hFFFD;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_BLK,
    SEQ_PROT
  } seq_st_e;
endpackage

// File: rtl/blk_cmd_seq.sv
`timescale 1ns/1ps
module blk_cmd_seq
  import blk_lock_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned NUM_BLK  = 8,
  parameter int unsigned BLK_LSB  = 12,
  parameter int unsigned LPA      = 32'h80,
  parameter int unsigned PR_BASE  = 32'h81,
  parameter int unsigned PR_WORDS = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [15:0]        data_i,
  input  logic               busy_i,
  input  logic               frozen_i,
  input  logic [NUM_BLK-1:0] ldown_i,
  output logic [NUM_BLK-1:0] sel_o,
  output logic               lock_o,
  output logic               unlock_o,
  output logic               ldown_set_o,
  output logic               freeze_o,
  output logic               prog_o,
  output logic               err_o
);
  localparam int unsigned HI_W = ADDR_W - BLK_LSB;
  localparam logic [ADDR_W-1:0] LPA_A   = ADDR_W'(LPA);
  localparam logic [ADDR_W-1:0] PR_LO_A = ADDR_W'(PR_BASE);
  localparam logic [ADDR_W-1:0] PR_HI_A = ADDR_W'(PR_BASE + PR_WORDS);

  seq_st_e           st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic              accept, open_cmd, same_addr, blk_ok, ld_hit, in_pr, bad;

  for (genvar i = 0; i < NUM_BLK; i++) begin : g_sel
    assign sel_o[i] = (addr_i[ADDR_W-1:BLK_LSB] == HI_W'(i));
  end

  assign accept    = wr_en_i & ~busy_i;
  assign open_cmd  = accept && (st_q == SEQ_IDLE) &&
                     ((data_i == OP_BLK) || (data_i == OP_PROT));
  assign same_addr = (addr_i == addr_q);
  assign blk_ok    = |sel_o;
  assign ld_hit    = |(sel_o & ldown_i);
  assign in_pr     = (addr_i >= PR_LO_A) && (addr_i < PR_HI_A);

  always_comb begin
    st_d        = st_q;
    lock_o      = 1'b0;
    unlock_o    = 1'b0;
    ldown_set_o = 1'b0;
    freeze_o    = 1'b0;
    prog_o      = 1'b0;
    bad         = 1'b0;
    if (accept) begin
      unique case (st_q)
        SEQ_IDLE: begin
          if (data_i == OP_BLK)       st_d = SEQ_BLK;
          else if (data_i == OP_PROT) st_d = SEQ_PROT;
        end
        SEQ_BLK: begin
          st_d = SEQ_IDLE;
          if (!same_addr || !blk_ok) bad = 1'b1;
          else begin
            unique case (data_i)
              SUB_LOCK:   lock_o = 1'b1;
              SUB_UNLOCK: if (ld_hit) bad = 1'b1; else unlock_o = 1'b1;
              SUB_LDOWN:  ldown_set_o = 1'b1;
              default:    bad = 1'b1;
            endcase
          end
        end
        SEQ_PROT: begin
          st_d = SEQ_IDLE;
          if (!same_addr) bad = 1'b1;
          else if (addr_i == LPA_A) begin
            if ((data_i == SUB_FREEZE) && !frozen_i) freeze_o = 1'b1;
            else bad = 1'b1;
          end else if (in_pr) begin
            if (frozen_i) bad = 1'b1;
            else prog_o = 1'b1;
          end else bad = 1'b1;
        end
        default: st_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SEQ_IDLE;
      addr_q <= '0;
      err_o  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (open_cmd) addr_q <= addr_i;
      if (bad)           err_o <= 1'b1;
      else if (open_cmd) err_o <= 1'b0;
    end
  end
endmodule

// File: rtl/blk_lock_bank.sv
`timescale 1ns/1ps
module blk_lock_bank #(
  parameter int unsigned NUM_BLK = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_BLK-1:0] sel_i,
  input  logic               lock_i,
  input  logic               unlock_i,
  input  logic               ldown_set_i,
  output logic [NUM_BLK-1:0] locked_o,
  output logic [NUM_BLK-1:0] ldown_o
);
  for (genvar i = 0; i < NUM_BLK; i++) begin : g_blk
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        locked_o[i] <= 1'b1;
        ldown_o[i]  <= 1'b0;
      end else if (sel_i[i]) begin
        if (lock_i) locked_o[i] <= 1'b1;
        if (ldown_set_i) begin
          locked_o[i] <= 1'b1;
          ldown_o[i]  <= 1'b1;
        end
        // lock-down blocks unlock here as well as upstream
        if (unlock_i && !ldown_o[i]) locked_o[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/blk_prot_ctrl.sv
`timescale 1ns/1ps
module blk_prot_ctrl #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_i,
  input  logic              freeze_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       data_i,
  input  logic              done_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [15:0]       data_o,
  output logic              frozen_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o    <= 1'b0;
      addr_o   <= '0;
      data_o   <= '0;
      frozen_o <= 1'b0;
    end else begin
      if (freeze_i) frozen_o <= 1'b1;
      if (prog_i && !req_o) begin
        req_o  <= 1'b1;
        addr_o <= addr_i;
        data_o <= data_i;
      end else if (req_o && done_i) begin
        req_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/blk_lock_dec.sv
`timescale 1ns/1ps
module blk_lock_dec #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned NUM_BLK  = 8,
  parameter int unsigned BLK_LSB  = 12,
  parameter int unsigned LPA      = 32'h80,
  parameter int unsigned PR_BASE  = 32'h81,
  parameter int unsigned PR_WORDS = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [15:0]        data_i,
  input  logic               prog_done_i,
  output logic [NUM_BLK-1:0] wp_o,
  output logic               err_o,
  output logic               prog_req_o,
  output logic [ADDR_W-1:0]  prog_addr_o,
  output logic [15:0]        prog_data_o
);
  logic [NUM_BLK-1:0] sel, ld_vec;
  logic lock, unlock, ldown_set, freeze, prog, prot_frz;

  blk_cmd_seq #(
    .ADDR_W(ADDR_W), .NUM_BLK(NUM_BLK), .BLK_LSB(BLK_LSB),
    .LPA(LPA), .PR_BASE(PR_BASE), .PR_WORDS(PR_WORDS)
  ) seq_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .data_i(data_i), .busy_i(prog_req_o), .frozen_i(prot_frz),
    .ldown_i(ld_vec), .sel_o(sel), .lock_o(lock), .unlock_o(unlock),
    .ldown_set_o(ldown_set), .freeze_o(freeze), .prog_o(prog), .err_o(err_o)
  );

  blk_lock_bank #(.NUM_BLK(NUM_BLK)) bank_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel), .lock_i(lock),
    .unlock_i(unlock), .ldown_set_i(ldown_set), .locked_o(wp_o), .ldown_o(ld_vec)
  );

  blk_prot_ctrl #(.ADDR_W(ADDR_W)) prot_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .prog_i(prog), .freeze_i(freeze),
    .addr_i(addr_i), .data_i(data_i), .done_i(prog_done_i), .req_o(prog_req_o),
    .addr_o(prog_addr_o), .data_o(prog_data_o), .frozen_o(prot_frz)
  );
endmodule

// File: rtl/blk_lock_dec_chk.sv
`timescale 1ns/1ps
module blk_lock_dec_chk #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned NUM_BLK  = 8,
  parameter int unsigned PR_BASE  = 32'h81,
  parameter int unsigned PR_WORDS = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [15:0]        data_i,
  input logic               prog_done_i,
  input logic [NUM_BLK-1:0] wp_o,
  input logic               prog_req_o,
  input logic [ADDR_W-1:0]  prog_addr_o,
  input logic [15:0]        prog_data_o,
  input logic [NUM_BLK-1:0] ld_i,
  input logic               frz_i
);
  AST_UNLOCK_BY_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(~wp_o & $past(wp_o))) |-> $past(wr_en_i && data_i == 16'h00D0)); // R3
  AST_LDOWN_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i & ~wp_o) == '0); // R4
  AST_LDOWN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ld_i) & ~ld_i) == '0); // R11
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_req_o && !prog_done_i |=> prog_req_o); // R7
  AST_REQ_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_req_o && $past(prog_req_o) |-> $stable(prog_addr_o) && $stable(prog_data_o)); // R7
  AST_REQ_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_req_o |-> (prog_addr_o >= ADDR_W'(PR_BASE)) &&
                   (prog_addr_o < ADDR_W'(PR_BASE + PR_WORDS))); // R7
  AST_FROZEN_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prog_req_o) |-> !$past(frz_i)); // R8
endmodule

bind blk_lock_dec blk_lock_dec_chk #(
  .ADDR_W(ADDR_W), .NUM_BLK(NUM_BLK), .PR_BASE(PR_BASE), .PR_WORDS(PR_WORDS)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .data_i(data_i),
  .prog_done_i(prog_done_i), .wp_o(wp_o), .prog_req_o(prog_req_o),
  .prog_addr_o(prog_addr_o), .prog_data_o(prog_data_o), .ld_i(ld_vec), .frz_i(prot_frz)
);

// File: tb/blk_lock_dec_tb_top.sv
`timescale 1ns/1ps
module blk_lock_dec_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] addr = '0;
  logic [15:0] data = '0;
  logic        done = 1'b0;
  logic [7:0]  wp;
  logic        err, req;
  logic [15:0] paddr, pdata;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  blk_lock_dec dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .data_i(data),
    .prog_done_i(done), .wp_o(wp), .err_o(err), .prog_req_o(req),
    .prog_addr_o(paddr), .prog_data_o(pdata)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    check("R1 wp", wp, 8'hFF);
    check("R1 err", err, 0);
    check("R1 req", req, 0);
  endtask

  task automatic t_lock_unlock();
    wr(16'h2000, 16'h0060); wr(16'h2000, 16'h00D0);
    check("R3 unlock blk2", wp, 8'hFB);
    check("R3 err", err, 0);
    wr(16'h7ABC, 16'h0060); wr(16'h7ABC, 16'h00D0);
    check("R3 unlock blk7", wp, 8'h7B);
    wr(16'h2000, 16'h0060); wr(16'h2000, 16'h0001);
    check("R2 relock blk2", wp, 8'h7F);
    check("R2 err", err, 0);
  endtask

  task automatic t_mismatch();
    wr(16'h3000, 16'h0060); wr(16'h4000, 16'h00D0);
    check("R5 mismatch err", err, 1);
    check("R5 wp unchanged", wp, 8'h7F);
    wr(16'h1000, 16'h00FF);
    check("R10 idle junk ignored err", err, 1);
    check("R10 idle junk wp", wp, 8'h7F);
    wr(16'h1000, 16'h0060);
    check("R10 prefix clears err", err, 0);
    wr(16'h1000, 16'h0055);
    check("R6 bad sub err", err, 1);
    check("R6 bad sub wp", wp, 8'h7F);
    wr(16'h8000, 16'h0060); wr(16'h8000, 16'h00D0);
    check("R6 block out of range err", err, 1);
    check("R6 out of range wp", wp, 8'h7F);
    wr(16'h00A0, 16'h00C0); wr(16'h0083, 16'h1111);
    check("R5 prot mismatch err", err, 1);
    check("R5 prot mismatch req", req, 0);
  endtask

  task automatic t_lockdown();
    wr(16'h5000, 16'h0060); wr(16'h5000, 16'h00D0);
    check("R3 unlock blk5", wp, 8'h5F);
    wr(16'h5004, 16'h0060); wr(16'h5004, 16'h002F);
    check("R4 lockdown sets wp", wp, 8'h7F);
    check("R4 lockdown err", err, 0);
    wr(16'h5000, 16'h0060); wr(16'h5000, 16'h00D0);
    check("R4 unlock refused wp", wp, 8'h7F);
    check("R4 unlock refused err", err, 1);
  endtask

  task automatic t_prog();
    wr(16'h0082, 16'h00C0); wr(16'h0082, 16'hBEEF);
    check("R7 req", req, 1);
    check("R7 addr", paddr, 16'h0082);
    check("R7 data", pdata, 16'hBEEF);
    check("R7 err", err, 0);
    wr(16'h0000, 16'h0060); wr(16'h0000, 16'h00D0);
    check("R7 busy writes ignored wp", wp, 8'h7F);
    check("R7 req held", req, 1);
    check("R7 data held", pdata, 16'hBEEF);
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
    check("R7 req drop", req, 0);
  endtask

  task automatic t_prot_bad();
    wr(16'h0090, 16'h00C0); wr(16'h0090, 16'h0001);
    check("R9 outside window err", err, 1);
    check("R9 outside window req", req, 0);
    wr(16'h0080, 16'h00C0);
    check("R10 C0 clears err", err, 0);
    wr(16'h0080, 16'h1234);
    check("R9 LPA bad data err", err, 1);
  endtask

  task automatic t_freeze();
    wr(16'h0080, 16'h00C0); wr(16'h0080, 16'hFFFD);
    check("R8 freeze err", err, 0);
    check("R8 freeze req", req, 0);
    wr(16'h0081, 16'h00C0); wr(16'h0081, 16'h0005);
    check("R8 frozen err", err, 1);
    check("R8 frozen req", req, 0);
  endtask

  task automatic t_reset_ldown();
    do_reset();
    check("R1 wp after reset", wp, 8'hFF);
    check("R1 err after reset", err, 0);
    wr(16'h5000, 16'h0060); wr(16'h5000, 16'h00D0);
    check("R11 lockdown cleared by reset", wp, 8'hDF);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lock_unlock();
    t_mismatch();
    t_lockdown();
    t_prog();
    t_prot_bad();
    t_freeze();
    t_reset_ldown();
    summary();
  end

  initial begin
    #2000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule